// File: doc/BRIEF.md
# Memory-Mapped I/O Address Decoder

This block gives a processor one 15-bit, word-addressed space of 16-bit words. That space holds three devices: a general data RAM, a screen frame buffer and a keyboard word. A single decoder looks at the top two address bits. It sends a write to at most one device and places the word of the selected device on the shared read bus. The lower half of the space is RAM, the next quarter is the screen, and the first word of the last quarter is the keyboard. Every other word in that last quarter is unmapped.

The keyboard word holds a copy of an external key-code input. That copy is taken on every clock, and 0 means no key is down. The screen buffer has a second, read-only port with a registered output, so a display scanner can fetch pixels without disturbing the processor.

Each storage device may keep fewer words than its address region covers. The parameters `RAM_AW` and `SCR_AW` set the number of stored words. The upper offset bits then alias. To build the full region sizes, set `RAM_AW=14` and `SCR_AW=13`.

Top module: `mmio_space`

## Requirements
- R1: With cpu_addr[14]=0 (words 0..16383), a write with cpu_load=1 stores cpu_wdata into RAM on the rising edge, and afterwards a read of that address returns it.
- R2: With cpu_addr[14:13]=2'b10 (words 16384..24575), the access goes to the screen buffer at word offset cpu_addr[12:0].
- R3: Address 24576 (cpu_addr[14:13]=2'b11, low 13 bits zero) reads the key_code value sampled at the previous rising edge. The keyboard word reads 0 during reset and in the cycle after reset.
- R4: A write to address 24576 is ignored and leaves the keyboard word and both memories unchanged.
- R5: Addresses 24577..32767 read as 0, and writes to them change no device.
- R6: A write changes only the addressed device. A RAM write never alters the screen word at the same offset, and a screen write never alters RAM.
- R7: With cpu_load=0, no device changes, whatever the address and data.
- R8: scan_data shows the screen word at scan_addr as it was just before the previous rising edge. It has one cycle of latency and works apart from the processor port. A processor write to the same word appears one cycle after the old value.
- R9: cpu_rdata is combinational in cpu_addr: changing the address changes the read word within the same cycle.
- R10: With the default parameters, RAM stores 4096 words and the screen stores 2048 words. Higher offset bits are ignored, so word 4096 aliases word 0 and word 16384+2048 aliases word 16384.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset (clears the keyboard word) |
| cpu_addr | input | 15 | Processor word address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_load | input | 1 | Write strobe |
| cpu_rdata | output | 16 | Word read from the selected device |
| scan_addr | input | 13 | Display scanner word address into the screen buffer |
| scan_data | output | 16 | Registered screen word for the scanner |
| key_code | input | 16 | External key code, 0 when no key is down |

## Verification
Reads are combinational, so a decode fault shows at the port as soon as the address moves. Such faults include a wrong region selected, a hole that does not read zero, or the keyboard read from the wrong place. Write-enable faults, such as a write that reaches two devices or a write to the keyboard that is not dropped, stay hidden until the damaged word is read back. For that reason the bench reads each neighbouring device right after every write. A stale or wrongly indexed scan register shows one cycle after the scan address is set, and the bench checks both the old and the new value of a word written while it is being scanned.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

  typedef enum logic [1:0] {
    DEV_RAM  = 2'd0,
    DEV_SCR  = 2'd1,
    DEV_KBD  = 2'd2,
    DEV_NONE = 2'd3
  } dev_e;

  // Region select from the top two address bits; the keyboard quarter is
  // only a single live word, the rest of it is a hole.
  function automatic dev_e decode_dev(input logic msb, input logic nsb,
                                      input logic low_zero);
    if (!msb)          return DEV_RAM;
    else if (!nsb)     return DEV_SCR;
    else if (low_zero) return DEV_KBD;
    else               return DEV_NONE;
  endfunction

endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
  import mmio_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16,
  localparam int RAM_IN_AW = ADDR_W - 1,
  localparam int SCR_IN_AW = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 load,
  input  logic [DATA_W-1:0]    ram_q,
  input  logic [DATA_W-1:0]    scr_q,
  input  logic [DATA_W-1:0]    kbd_q,
  output logic                 ram_we,
  output logic                 scr_we,
  output logic [RAM_IN_AW-1:0] ram_off,
  output logic [SCR_IN_AW-1:0] scr_off,
  output logic [DATA_W-1:0]    rdata
);

  dev_e dev;
  logic low_zero;

  assign low_zero = (addr[SCR_IN_AW-1:0] == '0);
  assign dev      = decode_dev(addr[ADDR_W-1], addr[ADDR_W-2], low_zero);

  // write demultiplex: keyboard and hole never receive a strobe
  assign ram_we  = load && (dev == DEV_RAM);
  assign scr_we  = load && (dev == DEV_SCR);
  assign ram_off = addr[RAM_IN_AW-1:0];
  assign scr_off = addr[SCR_IN_AW-1:0];

  // read multiplex
  always_comb begin
    unique case (dev)
      DEV_RAM: rdata = ram_q;
      DEV_SCR: rdata = scr_q;
      DEV_KBD: rdata = kbd_q;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/mmio_store.sv
module mmio_store #(
  parameter int IN_AW    = 14,
  parameter int AW       = 12,
  parameter int DW       = 16,
  parameter bit HAS_SCAN = 1'b0,
  localparam int DEPTH   = 1 << AW
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IN_AW-1:0] addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [IN_AW-1:0] scan_addr,
  output logic [DW-1:0]    scan_q
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] idx;
  logic [AW-1:0] sidx;

  // stored depth may be smaller than the decoded region: fold by truncation
  generate
    if (AW < IN_AW) begin : g_fold
      logic unused_hi;
      assign unused_hi = ^{addr[IN_AW-1:AW], scan_addr[IN_AW-1:AW]};
      assign idx  = addr[AW-1:0];
      assign sidx = scan_addr[AW-1:0];
    end else begin : g_full
      assign idx  = addr;
      assign sidx = scan_addr;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];

  // optional second read port, registered, read-before-write
  generate
    if (HAS_SCAN) begin : g_scan
      always_ff @(posedge clk) begin
        scan_q <= mem[sidx];
      end
    end else begin : g_noscan
      logic unused_scan;
      assign unused_scan = ^sidx;
      assign scan_q      = '0;
    end
  endgenerate

endmodule

// File: rtl/mmio_kbd.sv
module mmio_kbd #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] key_in,
  output logic [DW-1:0] key_q
);

  always_ff @(posedge clk) begin
    if (rst) key_q <= '0;
    else     key_q <= key_in;
  end

endmodule

// File: rtl/mmio_space.sv
module mmio_space #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16,
  parameter int RAM_AW = 12,
  parameter int SCR_AW = 11,
  localparam int RAM_IN_AW = ADDR_W - 1,
  localparam int SCR_IN_AW = ADDR_W - 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic [DATA_W-1:0]    cpu_wdata,
  input  logic                 cpu_load,
  output logic [DATA_W-1:0]    cpu_rdata,
  input  logic [SCR_IN_AW-1:0] scan_addr,
  output logic [DATA_W-1:0]    scan_data,
  input  logic [DATA_W-1:0]    key_code
);

  logic                 ram_we;
  logic                 scr_we;
  logic [RAM_IN_AW-1:0] ram_off;
  logic [SCR_IN_AW-1:0] scr_off;
  logic [DATA_W-1:0]    ram_q;
  logic [DATA_W-1:0]    scr_q;
  logic [DATA_W-1:0]    kbd_q;
  logic [DATA_W-1:0]    ram_scan_nc;

  mmio_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .addr    (cpu_addr),
    .load    (cpu_load),
    .ram_q   (ram_q),
    .scr_q   (scr_q),
    .kbd_q   (kbd_q),
    .ram_we  (ram_we),
    .scr_we  (scr_we),
    .ram_off (ram_off),
    .scr_off (scr_off),
    .rdata   (cpu_rdata)
  );

  mmio_store #(.IN_AW(RAM_IN_AW), .AW(RAM_AW), .DW(DATA_W), .HAS_SCAN(1'b0)) u_ram (
    .clk       (clk),
    .we        (ram_we),
    .addr      (ram_off),
    .wdata     (cpu_wdata),
    .rdata     (ram_q),
    .scan_addr ('0),
    .scan_q    (ram_scan_nc)
  );

  mmio_store #(.IN_AW(SCR_IN_AW), .AW(SCR_AW), .DW(DATA_W), .HAS_SCAN(1'b1)) u_scr (
    .clk       (clk),
    .we        (scr_we),
    .addr      (scr_off),
    .wdata     (cpu_wdata),
    .rdata     (scr_q),
    .scan_addr (scan_addr),
    .scan_q    (scan_data)
  );

  mmio_kbd #(.DW(DATA_W)) u_kbd (
    .clk    (clk),
    .rst    (rst),
    .key_in (key_code),
    .key_q  (kbd_q)
  );

  logic unused_nc;
  assign unused_nc = ^ram_scan_nc;

endmodule

// File: rtl/mmio_space_chk.sv
module mmio_space_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16,
  localparam int SCR_IN_AW = ADDR_W - 2,
  localparam logic [ADDR_W-1:0] KBD_ADDR = {2'b11, {(ADDR_W-2){1'b0}}}
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    cpu_addr,
  input logic [DATA_W-1:0]    cpu_wdata,
  input logic                 cpu_load,
  input logic [DATA_W-1:0]    cpu_rdata,
  input logic [SCR_IN_AW-1:0] scan_addr,
  input logic [DATA_W-1:0]    scan_data,
  input logic [DATA_W-1:0]    key_code,
  input logic                 ram_we,
  input logic                 scr_we
);

  logic scr_wr;
  assign scr_wr = cpu_load && (cpu_addr[ADDR_W-1:ADDR_W-2] == 2'b10);

  p_ram_readback_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(cpu_load) && !$past(cpu_addr[ADDR_W-1]) && cpu_addr == $past(cpu_addr))
      |-> cpu_rdata == $past(cpu_wdata));

  p_scr_readback_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(scr_wr) && cpu_addr == $past(cpu_addr))
      |-> cpu_rdata == $past(cpu_wdata));

  p_kbd_follow_r3: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr == KBD_ADDR && !$past(rst)) |-> cpu_rdata == $past(key_code));

  p_kbd_ro_r4: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr == KBD_ADDR) |-> !(ram_we || scr_we));

  p_hole_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr > KBD_ADDR) |-> (cpu_rdata == '0 && !ram_we && !scr_we));

  p_one_target_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_we, scr_we}));

  p_no_load_r7: assert property (@(posedge clk) disable iff (rst)
    !cpu_load |-> !(ram_we || scr_we));

  p_scan_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (scan_addr == $past(scan_addr) && !$past(scr_wr)) |=> $stable(scan_data));

endmodule

bind mmio_space mmio_space_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .cpu_load  (cpu_load),
  .cpu_rdata (cpu_rdata),
  .scan_addr (scan_addr),
  .scan_data (scan_data),
  .key_code  (key_code),
  .ram_we    (ram_we),
  .scr_we    (scr_we)
);

// File: tb/tb_mmio_space.sv
`timescale 1ns/1ps
module tb_mmio_space;

  logic        clk = 1'b0;
  logic        rst;
  logic [14:0] cpu_addr;
  logic [15:0] cpu_wdata;
  logic        cpu_load;
  logic [15:0] cpu_rdata;
  logic [12:0] scan_addr;
  logic [15:0] scan_data;
  logic [15:0] key_code;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  mmio_space dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_load(cpu_load), .cpu_rdata(cpu_rdata), .scan_addr(scan_addr),
    .scan_data(scan_data), .key_code(key_code)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_KEY = 2'd2;
  localparam int NV = 20;
  // {requirement, op, address, data/expected}
  localparam logic [36:0] VEC [NV] = '{
    {4'd1,  OP_WR,  15'd0,     16'h1111},  // R1
    {4'd1,  OP_WR,  15'd4095,  16'h2222},  // R1
    {4'd2,  OP_WR,  15'd16384, 16'h3333},  // R2
    {4'd2,  OP_WR,  15'd24575, 16'h4444},  // R2 top screen word
    {4'd1,  OP_RD,  15'd0,     16'h1111},
    {4'd1,  OP_RD,  15'd4095,  16'h2222},
    {4'd2,  OP_RD,  15'd16384, 16'h3333},
    {4'd2,  OP_RD,  15'd24575, 16'h4444},
    {4'd5,  OP_WR,  15'd24577, 16'h5555},  // R5 hole write
    {4'd5,  OP_RD,  15'd24577, 16'h0000},
    {4'd5,  OP_RD,  15'd32767, 16'h0000},
    {4'd3,  OP_KEY, 15'd24576, 16'h0041},  // R3
    {4'd3,  OP_RD,  15'd24576, 16'h0041},
    {4'd4,  OP_WR,  15'd24576, 16'h7777},  // R4
    {4'd4,  OP_RD,  15'd24576, 16'h0041},
    {4'd6,  OP_WR,  15'd1,     16'hAAAA},  // R6
    {4'd6,  OP_WR,  15'd16385, 16'hBBBB},
    {4'd6,  OP_RD,  15'd1,     16'hAAAA},
    {4'd6,  OP_RD,  15'd16385, 16'hBBBB},
    {4'd4,  OP_RD,  15'd4095,  16'h2222}   // R4/R5 writes left RAM alone
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cpu_write(input logic [14:0] a, input logic [15:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_load = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cpu_load = 1'b0;
  endtask

  task automatic cpu_read(input string req, input logic [14:0] a, input logic [15:0] exp);
    @(negedge clk);
    cpu_addr = a;
    #1 check(req, cpu_rdata, exp);
  endtask

  task automatic set_key(input logic [15:0] k);
    @(negedge clk);
    key_code = k;
    @(posedge clk);
  endtask

  initial begin
    rst = 1'b1; cpu_addr = '0; cpu_wdata = '0; cpu_load = 1'b0;
    scan_addr = '0; key_code = 16'h0055;
    repeat (3) @(posedge clk);
    // R3: keyboard word is zero while reset holds, despite a pressed key
    cpu_read("R3 reset", 15'd24576, 16'h0000);
    @(negedge clk); rst = 1'b0; key_code = 16'h0000;
    @(posedge clk);
    cpu_read("R3 idle", 15'd24576, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      automatic logic [3:0]  rq = VEC[i][36:33];
      automatic logic [1:0]  op = VEC[i][32:31];
      automatic logic [14:0] a  = VEC[i][30:16];
      automatic logic [15:0] d  = VEC[i][15:0];
      case (op)
        OP_WR:   cpu_write(a, d);
        OP_KEY:  set_key(d);
        default: cpu_read($sformatf("R%0d vec%0d", rq, i), a, d);
      endcase
    end

    // R9: address change without a clock edge
    @(negedge clk);
    cpu_addr = 15'd0;     #0.5 check("R9 ram", cpu_rdata, 16'h1111);
    cpu_addr = 15'd16384; #0.5 check("R9 scr", cpu_rdata, 16'h3333);
    cpu_addr = 15'd24576; #0.5 check("R9 kbd", cpu_rdata, 16'h0041);

    // R7: strobe low leaves RAM untouched
    @(negedge clk);
    cpu_addr = 15'd0; cpu_wdata = 16'hFFFF; cpu_load = 1'b0;
    @(posedge clk);
    cpu_read("R7", 15'd0, 16'h1111);

    // R10: aliasing of the stored depths
    cpu_read("R10 ram", 15'd4096, 16'h1111);
    cpu_read("R10 scr", 15'd18432, 16'h3333);

    // R8: scanner port latency and read-before-write
    cpu_write(15'd16389, 16'hCAFE);
    @(negedge clk); scan_addr = 13'd5; cpu_addr = 15'd0;
    @(posedge clk); @(negedge clk);
    check("R8 scan", scan_data, 16'hCAFE);
    check("R8 cpu independent", cpu_rdata, 16'h1111);
    cpu_write(15'd16389, 16'hBEEF);
    check("R8 old value", scan_data, 16'hCAFE);
    @(posedge clk); @(negedge clk);
    check("R8 new value", scan_data, 16'hBEEF);

    // R3: key release
    set_key(16'h0000);
    cpu_read("R3 release", 15'd24576, 16'h0000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule